// File: doc/BRIEF.md
# Dual-Mode Serial Shift Unit with Two-Wire Bus Events

This block receives and sends bytes on a two-line serial port made of a clock line and a data line. It has two modes. In clocked mode it moves eight bits per byte on one selectable edge of an externally supplied clock. In I2C mode it frames each transfer as nine clocks, eight data bits and an acknowledge bit. It also watches the bus for start and stop conditions. Both input lines pass through a synchronizer. All behaviour follows edges that are found on the synchronized levels.

Each received byte is copied into a receive buffer. In clocked mode the first bit lands in the LSB. In I2C mode the first bit lands in the MSB. Single-cycle event pulses mark transmit, receive, acknowledge, no-acknowledge, start and stop. A DMA request strobe goes with them. In I2C mode an event-select input moves the byte-end events between the rising edge and the falling edge of the ninth clock. The outgoing data bit follows the transmit byte. In I2C mode it changes a fixed number of system clocks after each clock fall. While the unit is disabled it drives a preset level. Mode and select inputs may change only while the unit is disabled.

Top module: `serx_dual`

## Requirements
- R1: While rst_ni is low, every event output and rx_buf_o are 0 and sda_o is 1.
- R2: While en_i is 0, no event pulse occurs and the bit count is cleared. On the next clock sda_o takes the value of sda_init_i.
- R3: In clocked mode (mode_i=0), ckpol_i=0 samples data on rising edges of the clock line and ckpol_i=1 samples on falling edges. The other edge is the inactive edge.
- R4: In clocked mode, on the 8th active edge the byte is copied to rx_buf_o with the first received bit in bit 0. ev_rx_o and dma_req_o pulse together and the count restarts.
- R5: In clocked mode, ev_tx_o pulses on the first active edge of a byte when txsel_i=0, and on the 8th active edge when txsel_i=1.
- R6: In clocked mode, sda_o carries tx_data_i[0] while no bit has been sampled. After the n-th active edge it changes on the next inactive edge to tx_data_i[n].
- R7: In I2C mode (mode_i=1) bits are sampled on clock rising edges and the first bit goes to rx_buf_o bit 7. With evsel_i=0, the 9th rising edge loads rx_buf_o and pulses ev_ack_o with dma_req_o when the data line is low, or ev_nack_o when it is high. ev_tx_o and ev_rx_o stay 0.
- R8: In I2C mode with evsel_i=1, rx_buf_o is loaded on the 8th falling edge and again on the 9th rising edge. ev_tx_o, ev_rx_o and dma_req_o pulse on the 9th falling edge. ev_ack_o and ev_nack_o stay 0.
- R9: In I2C mode, a data-line fall while the clock line is high pulses ev_start_o and a data-line rise while it is high pulses ev_stop_o. Either one restarts the bit count, so a repeated start within a byte begins a new byte.
- R10: In I2C mode, sda_o keeps its preset until the first clock fall. SDA_DLY system clocks after each clock fall it takes tx_data_i[7-n], where n is the number of data bits already clocked. During the acknowledge slot it takes 1.
- R11: An edge on either line that is first sampled at clock edge k changes the outputs at clock edge k+2, with SYNC_STAGES=2.
- R12: Every event output is a single-cycle pulse, and ev_ack_o and ev_nack_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enable |
| mode_i | input | 1 | 0 clocked mode, 1 I2C mode |
| evsel_i | input | 1 | I2C byte-end event point: 0 rising edge of the 9th clock, 1 falling edge |
| ckpol_i | input | 1 | Clocked-mode active edge: 0 rising, 1 falling |
| txsel_i | input | 1 | Clocked-mode transmit event: 0 at byte start, 1 at byte end |
| sda_init_i | input | 1 | Data output level preset while disabled |
| tx_data_i | input | DW | Byte to send |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_o | output | 1 | Serial data output level |
| rx_buf_o | output | DW | Receive buffer |
| ev_tx_o | output | 1 | Transmit event pulse |
| ev_rx_o | output | 1 | Receive event pulse |
| ev_ack_o | output | 1 | Acknowledge event pulse |
| ev_nack_o | output | 1 | No-acknowledge event pulse |
| ev_start_o | output | 1 | Start condition pulse |
| ev_stop_o | output | 1 | Stop condition pulse |
| dma_req_o | output | 1 | DMA request strobe |

## Verification
A line transition that is first sampled at clock edge k shows up at the outputs at edge k+2: two synchronizer stages plus the registered event stage. A data-output update in I2C mode lands SDA_DLY edges after the edge where the clock fall was found. The bench model keeps its own three-deep history of each line, acts on the samples two and three edges old, and counts the data delay down in cycles. Outputs are compared at every falling clock edge, away from the edges where they change. Each byte is also checked directly against its known value once the line activity has settled.

// File: rtl/serx_pkg.sv
package serx_pkg;
  typedef enum logic {
    SERX_CLKD = 1'b0,
    SERX_I2C  = 1'b1
  } serx_mode_e;

  typedef struct packed {
    logic tx;
    logic rx;
    logic ack;
    logic nack;
    logic start;
    logic stop;
    logic dma;
  } serx_ev_t;
endpackage

// File: rtl/serx_sync.sv
module serx_sync #(
  parameter int          N       = 2,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  // STAGES sync flops plus one history flop
  logic [STAGES:0][N-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= RST_VAL;
    else         pipe_q[0] <= din_i;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= RST_VAL;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/serx_rx_core.sv
module serx_rx_core
  import serx_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  serx_mode_e    mode_i,
  input  logic          evsel_i,
  input  logic          ckpol_i,
  input  logic          txsel_i,
  input  logic          scl_lvl_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_lvl_i,
  input  logic          sda_rise_i,
  input  logic          sda_fall_i,
  output serx_ev_t      ev_o,
  output logic [DW-1:0] rx_buf_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] C_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] C_ACK  = CW'(DW);
  localparam logic [CW-1:0] C_END  = CW'(DW + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic          act_edge;
  logic          bus_start, bus_stop;

  assign act_edge  = ckpol_i ? scl_fall_i : scl_rise_i;
  assign bus_start = sda_fall_i & scl_lvl_i;
  assign bus_stop  = sda_rise_i & scl_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      rx_buf_o <= '0;
      ev_o     <= '0;
    end else begin
      ev_o <= '0;
      if (!en_i) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (mode_i == SERX_CLKD) begin
        if (act_edge) begin
          sh_q <= {sda_lvl_i, sh_q[DW-1:1]};
          if (cnt_q == '0 && !txsel_i) ev_o.tx <= 1'b1;
          if (cnt_q == C_LAST) begin
            cnt_q    <= '0;
            rx_buf_o <= {sda_lvl_i, sh_q[DW-1:1]};
            ev_o.rx  <= 1'b1;
            ev_o.dma <= 1'b1;
            if (txsel_i) ev_o.tx <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else begin
        if (bus_start) begin
          ev_o.start <= 1'b1;
          cnt_q      <= '0;
        end else if (bus_stop) begin
          ev_o.stop <= 1'b1;
          cnt_q     <= '0;
        end else if (scl_rise_i) begin
          if (cnt_q < C_ACK) begin
            sh_q  <= {sh_q[DW-2:0], sda_lvl_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (cnt_q == C_ACK) begin
            cnt_q    <= C_END;
            rx_buf_o <= sh_q;
            if (!evsel_i) begin
              ev_o.ack  <= ~sda_lvl_i;
              ev_o.nack <= sda_lvl_i;
              ev_o.dma  <= ~sda_lvl_i;
            end
          end
        end else if (scl_fall_i) begin
          if (cnt_q == C_ACK && evsel_i) rx_buf_o <= sh_q;
          if (cnt_q == C_END) begin
            cnt_q <= '0;
            if (evsel_i) begin
              ev_o.tx  <= 1'b1;
              ev_o.rx  <= 1'b1;
              ev_o.dma <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/serx_tx_drive.sv
module serx_tx_drive
  import serx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DLY = 2,
  localparam int CW = $clog2(DW + 2),
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  serx_mode_e    mode_i,
  input  logic          ckpol_i,
  input  logic          sda_init_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  output logic          sda_o
);
  localparam logic [CW-1:0] C_ACK = CW'(DW);

  logic [DLY-1:0] fpipe_q;
  logic           inact_edge;
  logic [IW-1:0]  lsb_idx, msb_idx;
  logic           i2c_bit;

  assign inact_edge = ckpol_i ? scl_rise_i : scl_fall_i;
  assign lsb_idx    = cnt_i[IW-1:0];
  assign msb_idx    = IW'(DW - 1) - cnt_i[IW-1:0];
  assign i2c_bit    = (cnt_i < C_ACK) ? tx_data_i[msb_idx] : 1'b1;

  // delay line of clock-fall strobes
  if (DLY == 1) begin : g_dly1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             fpipe_q <= '0;
      else if (!en_i || mode_i == SERX_CLKD)   fpipe_q <= '0;
      else                                     fpipe_q <= scl_fall_i;
    end
  end else begin : g_dlyn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             fpipe_q <= '0;
      else if (!en_i || mode_i == SERX_CLKD)   fpipe_q <= '0;
      else                                     fpipe_q <= {fpipe_q[DLY-2:0], scl_fall_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_o <= 1'b1;
    end else if (!en_i) begin
      sda_o <= sda_init_i;
    end else if (mode_i == SERX_CLKD) begin
      if (cnt_i == '0 || inact_edge) sda_o <= tx_data_i[lsb_idx];
    end else if (fpipe_q[DLY-1]) begin
      sda_o <= i2c_bit;
    end
  end
endmodule

// File: rtl/serx_dual.sv
module serx_dual
  import serx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SDA_DLY     = 2,
  localparam int CW = $clog2(DW + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          mode_i,
  input  logic          evsel_i,
  input  logic          ckpol_i,
  input  logic          txsel_i,
  input  logic          sda_init_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_o,
  output logic [DW-1:0] rx_buf_o,
  output logic          ev_tx_o,
  output logic          ev_rx_o,
  output logic          ev_ack_o,
  output logic          ev_nack_o,
  output logic          ev_start_o,
  output logic          ev_stop_o,
  output logic          dma_req_o
);
  serx_mode_e    mode;
  logic [1:0]    lvl, rise, fall;
  serx_ev_t      ev;
  logic [CW-1:0] cnt;

  assign mode = serx_mode_e'(mode_i);

  // bit 1 = clock line, bit 0 = data line
  serx_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i ({scl_i, sda_i}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  serx_rx_core #(.DW(DW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode),
    .evsel_i   (evsel_i),
    .ckpol_i   (ckpol_i),
    .txsel_i   (txsel_i),
    .scl_lvl_i (lvl[1]),
    .scl_rise_i(rise[1]),
    .scl_fall_i(fall[1]),
    .sda_lvl_i (lvl[0]),
    .sda_rise_i(rise[0]),
    .sda_fall_i(fall[0]),
    .ev_o      (ev),
    .rx_buf_o  (rx_buf_o),
    .cnt_o     (cnt)
  );

  serx_tx_drive #(.DW(DW), .DLY(SDA_DLY)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode),
    .ckpol_i   (ckpol_i),
    .sda_init_i(sda_init_i),
    .tx_data_i (tx_data_i),
    .cnt_i     (cnt),
    .scl_rise_i(rise[1]),
    .scl_fall_i(fall[1]),
    .sda_o     (sda_o)
  );

  assign ev_tx_o    = ev.tx;
  assign ev_rx_o    = ev.rx;
  assign ev_ack_o   = ev.ack;
  assign ev_nack_o  = ev.nack;
  assign ev_start_o = ev.start;
  assign ev_stop_o  = ev.stop;
  assign dma_req_o  = ev.dma;
endmodule

// File: rtl/serx_dual_chk.sv
module serx_dual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic mode_i,
  input logic evsel_i,
  input logic sda_init_i,
  input logic sda_o,
  input logic ev_tx_o,
  input logic ev_rx_o,
  input logic ev_ack_o,
  input logic ev_nack_o,
  input logic ev_start_o,
  input logic ev_stop_o,
  input logic dma_req_o
);
  logic any_ev;
  assign any_ev = ev_tx_o | ev_rx_o | ev_ack_o | ev_nack_o | ev_start_o | ev_stop_o | dma_req_o;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !any_ev); // R2
  AST_IDLE_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sda_o == $past(sda_init_i)); // R2
  AST_CLKD_NO_BUS_EV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mode_i) |=> !(ev_ack_o || ev_nack_o || ev_start_o || ev_stop_o)); // R4
  AST_SEL0_NO_TXRX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i && !evsel_i) |=> !(ev_tx_o || ev_rx_o)); // R7
  AST_SEL1_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i && evsel_i) |=> !(ev_ack_o || ev_nack_o)); // R8
  AST_ACK_NACK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_ack_o, ev_nack_o})); // R12
  AST_RX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rx_o |=> !ev_rx_o); // R12
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_start_o |=> !ev_start_o); // R12
endmodule

bind serx_dual serx_dual_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .mode_i    (mode_i),
  .evsel_i   (evsel_i),
  .sda_init_i(sda_init_i),
  .sda_o     (sda_o),
  .ev_tx_o   (ev_tx_o),
  .ev_rx_o   (ev_rx_o),
  .ev_ack_o  (ev_ack_o),
  .ev_nack_o (ev_nack_o),
  .ev_start_o(ev_start_o),
  .ev_stop_o (ev_stop_o),
  .dma_req_o (dma_req_o)
);

// File: tb/tb_serx_dual.sv
module tb_serx_dual;
  localparam int DLY = 2;
  localparam int H   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, mode = 0, evsel = 0, ckpol = 0, txsel = 0, sda_init = 1;
  logic [7:0] tx_data = 8'h00;
  logic scl = 1, sda = 1;
  logic sda_o, ev_tx, ev_rx, ev_ack, ev_nack, ev_start, ev_stop, dma;
  logic [7:0] rx_buf;

  int vectors = 0;
  int fails = 0;
  string ph = "R1";

  always #4 clk = ~clk;

  serx_dual dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .evsel_i(evsel),
    .ckpol_i(ckpol), .txsel_i(txsel), .sda_init_i(sda_init), .tx_data_i(tx_data),
    .scl_i(scl), .sda_i(sda), .sda_o(sda_o), .rx_buf_o(rx_buf),
    .ev_tx_o(ev_tx), .ev_rx_o(ev_rx), .ev_ack_o(ev_ack), .ev_nack_o(ev_nack),
    .ev_start_o(ev_start), .ev_stop_o(ev_stop), .dma_req_o(dma)
  );

  // ---------------- behavioural reference model ----------------
  int hs_c[3] = '{1, 1, 1};
  int hs_d[3] = '{1, 1, 1};
  int m_cnt = 0, pend = 0;
  logic [7:0] m_sh = 0;
  logic [7:0] e_buf = 0;
  logic e_sda = 1, e_tx = 0, e_rx = 0, e_ack = 0, e_nack = 0, e_start = 0, e_stop = 0, e_dma = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (hs_c[i]) begin hs_c[i] = 1; hs_d[i] = 1; end
      m_cnt = 0; pend = 0; m_sh = 0; e_buf = 0; e_sda = 1;
      {e_tx, e_rx, e_ack, e_nack, e_start, e_stop, e_dma} = '0;
    end else begin
      // R11: act on samples two and three edges old
      bit c_now, c_old, d_now, d_old, c_up, c_dn, d_up, d_dn, act, inact;
      c_now = hs_c[1][0]; c_old = hs_c[2][0];
      d_now = hs_d[1][0]; d_old = hs_d[2][0];
      c_up = c_now && !c_old; c_dn = !c_now && c_old;
      d_up = d_now && !d_old; d_dn = !d_now && d_old;
      act   = ckpol ? c_dn : c_up;
      inact = ckpol ? c_up : c_dn;
      {e_tx, e_rx, e_ack, e_nack, e_start, e_stop, e_dma} = '0;
      // data output
      if (!en) begin
        e_sda = sda_init; pend = 0;
      end else if (!mode) begin
        pend = 0;
        if (m_cnt == 0 || inact) e_sda = tx_data[m_cnt];
      end else begin
        if (pend > 0) begin
          pend--;
          if (pend == 0) e_sda = (m_cnt < 8) ? tx_data[7 - m_cnt] : 1'b1;
        end
        if (c_dn) pend = DLY;
      end
      // receive side
      if (!en) begin
        m_cnt = 0; m_sh = 0;
      end else if (!mode) begin
        if (act) begin
          m_sh = {d_now, m_sh[7:1]};
          if (m_cnt == 0 && !txsel) e_tx = 1;
          m_cnt++;
          if (m_cnt == 8) begin
            m_cnt = 0; e_buf = m_sh; e_rx = 1; e_dma = 1;
            if (txsel) e_tx = 1;
          end
        end
      end else begin
        if (d_dn && c_now) begin e_start = 1; m_cnt = 0; end
        else if (d_up && c_now) begin e_stop = 1; m_cnt = 0; end
        else if (c_up) begin
          if (m_cnt < 8) begin m_sh = {m_sh[6:0], d_now}; m_cnt++; end
          else if (m_cnt == 8) begin
            m_cnt = 9; e_buf = m_sh;
            if (!evsel) begin e_ack = !d_now; e_nack = d_now; e_dma = !d_now; end
          end
        end else if (c_dn) begin
          if (m_cnt == 8 && evsel) e_buf = m_sh;
          if (m_cnt == 9) begin
            m_cnt = 0;
            if (evsel) begin e_tx = 1; e_rx = 1; e_dma = 1; end
          end
        end
      end
      hs_c[2] = hs_c[1]; hs_c[1] = hs_c[0]; hs_c[0] = scl;
      hs_d[2] = hs_d[1]; hs_d[1] = hs_d[0]; hs_d[0] = sda;
    end
  end

  task automatic chk(string req, string nm, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s actual=%h expected=%h t=%0t", req, ph, nm, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    string r_buf, r_sda, r_txrx;
    vectors++;
    r_buf  = !rst_n ? "R1" : (!mode ? "R4" : (evsel ? "R8" : "R7"));
    r_sda  = !rst_n ? "R1" : (!en ? "R2" : (!mode ? "R6" : "R10"));
    r_txrx = !rst_n ? "R1" : (!mode ? "R5" : "R8");
    chk(r_buf, "rx_buf", rx_buf, e_buf);
    chk(r_sda, "sda_o", {7'd0, sda_o}, {7'd0, e_sda});
    chk(r_txrx, "ev_tx", {7'd0, ev_tx}, {7'd0, e_tx});
    chk(r_txrx, "ev_rx", {7'd0, ev_rx}, {7'd0, e_rx});
    chk("R7", "ev_ack", {7'd0, ev_ack}, {7'd0, e_ack});
    chk("R7", "ev_nack", {7'd0, ev_nack}, {7'd0, e_nack});
    chk("R9", "ev_start", {7'd0, ev_start}, {7'd0, e_start});
    chk("R9", "ev_stop", {7'd0, ev_stop}, {7'd0, e_stop});
    chk(r_txrx, "dma_req", {7'd0, dma}, {7'd0, e_dma});
    chk("R12", "ack_and_nack", {7'd0, ev_ack & ev_nack}, 8'd0);
  end

  // ---------------- stimulus ----------------
  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv(logic c, logic d);
    scl = c; sda = d; hold(H);
  endtask

  task automatic cfg(logic m, logic es, logic cp, logic ts, logic init, logic c_idle);
    en = 0; hold(2);
    mode = m; evsel = es; ckpol = cp; txsel = ts; sda_init = init;
    scl = c_idle; sda = 1; hold(6);
    en = 1; hold(3);
  endtask

  task automatic clkd_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (!ckpol) begin drv(0, b[i]); drv(1, b[i]); end
      else        begin drv(1, b[i]); drv(0, b[i]); end
    end
    hold(4);
  endtask

  task automatic i2c_start();
    drv(scl, 1); drv(1, 1); drv(1, 0); drv(0, 0);
  endtask

  task automatic i2c_bits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      drv(0, b[7-i]); drv(1, b[7-i]); drv(0, b[7-i]);
    end
  endtask

  task automatic i2c_ack(logic a);
    drv(0, a); drv(1, a); drv(0, a);
  endtask

  task automatic i2c_stop();
    drv(0, 0); drv(1, 0); drv(1, 1);
  endtask

  task automatic direct(string req, string nm, logic [7:0] act, logic [7:0] exp);
    vectors++;
    chk(req, nm, act, exp);
  endtask

  initial begin
    hold(3);
    ph = "R1";
    direct("R1", "reset rx_buf", rx_buf, 8'h00);
    direct("R1", "reset sda_o", {7'd0, sda_o}, 8'h01);
    rst_n = 1; hold(3);

    // R2: disabled, line activity ignored, preset followed
    ph = "R2";
    sda_init = 0; drv(0, 0); drv(1, 1); drv(0, 1); drv(1, 0);
    direct("R2", "disabled sda_o preset", {7'd0, sda_o}, 8'h00);
    direct("R2", "disabled rx_buf untouched", rx_buf, 8'h00);
    sda_init = 1; hold(2);

    // R3 R4 R5 R6: clocked mode, rising edge, tx event at start
    ph = "R3";
    tx_data = 8'h5A;
    cfg(0, 0, 0, 0, 1, 1);
    clkd_byte(8'hA5);
    direct("R4", "clkd lsb-first byte", rx_buf, 8'hA5);
    ph = "R5";
    tx_data = 8'hC3;
    cfg(0, 0, 0, 1, 1, 1);
    clkd_byte(8'h3C);
    direct("R4", "clkd byte txsel1", rx_buf, 8'h3C);
    ph = "R3";
    tx_data = 8'h96;
    cfg(0, 0, 1, 0, 0, 0);
    clkd_byte(8'h81);
    direct("R3", "clkd falling-edge byte", rx_buf, 8'h81);
    clkd_byte(8'h7E);
    direct("R4", "clkd back-to-back byte", rx_buf, 8'h7E);

    // R7 R10 R11: I2C, events at 9th rising edge
    ph = "R7";
    tx_data = 8'hB4;
    cfg(1, 0, 0, 0, 1, 1);
    i2c_start();
    i2c_bits(8'hD2, 8); i2c_ack(0);
    direct("R7", "i2c msb-first byte", rx_buf, 8'hD2);
    ph = "R10";
    i2c_bits(8'h4B, 8); i2c_ack(1);
    direct("R7", "i2c second byte nack", rx_buf, 8'h4B);
    i2c_stop();

    // R8 R9: I2C event select 1, repeated start mid-byte
    ph = "R8";
    tx_data = 8'h69;
    cfg(1, 1, 0, 0, 0, 1);
    i2c_start();
    ph = "R9";
    i2c_bits(8'hF0, 3);
    i2c_start();
    ph = "R8";
    i2c_bits(8'h1E, 8);
    direct("R8", "buffer after 8th falling", rx_buf, 8'h1E);
    i2c_ack(0);
    direct("R8", "buffer after 9th clock", rx_buf, 8'h1E);
    ph = "R11";
    i2c_bits(8'hE7, 8); i2c_ack(1);
    direct("R8", "i2c sel1 second byte", rx_buf, 8'hE7);
    ph = "R12";
    i2c_stop();
    hold(6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule